// File: doc/BRIEF.md
# Dual Edge-Qualified Binary Counter

This block holds a set of independent 4-bit binary up-counters, two by default, clocked from one system clock. Each counter has two count-control inputs. The first counts on its low-to-high transitions. The second counts on its high-to-low transitions. Each input gates the other, so either one can serve as the count source while the other acts as an enable. Both inputs are synchronized to the system clock, and edges are found by comparing successive synchronized samples.

Each counter has its own active-high clear. The clear zeroes the count at once, without waiting for a clock edge. It is released to the clock domain through a short hold window, so that a resynchronized input cannot produce a count that never happened at the pin. A terminal-count flag per counter supports cascading.

The usual use is to drive one control input with a slow event signal and tie or steer the other as an enable. The count and the flag are read on every system clock.

Top module: `twin_gated_counter`

## Requirements
- R1: Each counter is an unsigned 4-bit up-counter on `cnt_o[g]`, with bit 0 as the LSB. Every qualifying event adds exactly one, and the new value appears within four system-clock cycles of the input change.
- R2: A low-to-high change on `rise_i[g]` adds one when `fall_i[g]` was high in the synchronized sample just before that change.
- R3: A high-to-low change on `fall_i[g]` adds one when `rise_i[g]` was low in the synchronized sample just before that change.
- R4: Some changes never count. A rising change on `rise_i[g]` while `fall_i[g]` was low does not count. A falling change on `fall_i[g]` while `rise_i[g]` was high does not count. Falling changes on `rise_i[g]` and rising changes on `fall_i[g]` never count.
- R5: A qualifying rise and a qualifying fall that land in the same synchronized sample add exactly one, not two.
- R6: The count wraps from 15 to 0 on the next qualifying event. `tc_o[g]` is high exactly while the count is 15.
- R7: While `clr_i[g]` is high, `cnt_o[g]` is 0 at once, without waiting for a clock edge, and no event counts. After release, steady inputs produce no count, and later qualifying events count normally.
- R8: `rst_ni` low zeroes all counters asynchronously. Inputs that are steady while the reset is released produce no count.
- R9: Counters are independent. Events and clears on one counter leave the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Global asynchronous reset, active low |
| rise_i | input | NUM_CTR | Per-counter control input that counts on its rising edges |
| fall_i | input | NUM_CTR | Per-counter control input that counts on its falling edges |
| clr_i | input | NUM_CTR | Per-counter asynchronous clear, active high |
| cnt_o | output | NUM_CTR x CNT_W | Count value of each counter |
| tc_o | output | NUM_CTR | High while the matching count is at its maximum |

## Verification
Two count paths can fire in the same cycle. A rise on the rising-edge input while the other input is high, and a fall on the falling-edge input while the other input is low, can both be detected in one synchronized sample. The bench provokes this by switching both inputs of a counter at the same instant, so that they pass through the synchronizers together. It walks every ordered pair of input states in this way and predicts the increment arithmetically from the previous and new levels. For the simultaneous rise-and-fall case it expects exactly one added count. The clear is also applied while edges are arriving, to show that the clear wins and that its release adds no count.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int unsigned CTR_W  = 4;
  localparam int unsigned SYNC_N = 2;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned STAGES = ctr_pkg::SYNC_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/edge_qual.sv
module edge_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,     // synchronized rising-edge input
  input  logic b_i,     // synchronized falling-edge input
  output logic step_o
);
  logic a_prev_q, b_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a_i;
      b_prev_q <= b_i;
    end
  end

  // The enable level is taken from the sample before the edge.
  logic a_hit, b_hit;
  assign a_hit  = a_i & ~a_prev_q & b_prev_q;
  assign b_hit  = ~b_i & b_prev_q & ~a_prev_q;
  assign step_o = a_hit | b_hit;

  // R4
  blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(b_i) && $past(a_i)) |-> !step_o);

  // R4
  step_needs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> ((a_i != $past(a_i)) || (b_i != $past(b_i))));
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int unsigned CNT_W  = ctr_pkg::CTR_W,
  parameter int unsigned SYNC_N = ctr_pkg::SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);
  localparam int unsigned HOLD_N = SYNC_N + 1;

  logic              arst_n;
  logic [HOLD_N-1:0] hold_q;
  logic              hold;
  logic [CNT_W-1:0]  cnt_q;

  assign arst_n = rst_ni & ~clr_i;

  // Hold window covers synchronizer refill after any reset.
  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) hold_q <= '1;
    else         hold_q <= {hold_q[HOLD_N-2:0], 1'b0};
  end
  assign hold = hold_q[HOLD_N-1];

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n)             cnt_q <= '0;
    else if (!hold && step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign tc_o  = &cnt_q;

  // R1
  single_step_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
    (!hold && !$past(hold) && cnt_q != $past(cnt_q)) |-> cnt_q == $past(cnt_q) + 1'b1);

  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
    (!hold && !$past(hold) && $past(tc_o) && $past(step_i)) |-> cnt_q == '0);

  // R6
  tc_rise_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
    $rose(tc_o) |-> $past(cnt_q) == {{(CNT_W-1){1'b1}}, 1'b0});

  // R7
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> cnt_q == '0);
endmodule

// File: rtl/twin_gated_counter.sv
module twin_gated_counter #(
  parameter int unsigned NUM_CTR = 2,
  parameter int unsigned CNT_W   = ctr_pkg::CTR_W,
  parameter int unsigned SYNC_N  = ctr_pkg::SYNC_N
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_CTR-1:0]              rise_i,
  input  logic [NUM_CTR-1:0]              fall_i,
  input  logic [NUM_CTR-1:0]              clr_i,
  output logic [NUM_CTR-1:0][CNT_W-1:0]   cnt_o,
  output logic [NUM_CTR-1:0]              tc_o
);
  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic a_s, b_s, step;

    bit_sync #(.STAGES(SYNC_N)) u_sync_a (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rise_i[g]), .q_o(a_s));
    bit_sync #(.STAGES(SYNC_N)) u_sync_b (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fall_i[g]), .q_o(b_s));

    edge_qual u_qual (
      .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_s), .b_i(b_s), .step_o(step));

    count_core #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i[g]), .step_i(step),
      .cnt_o(cnt_o[g]), .tc_o(tc_o[g]));
  end
endmodule

// File: tb/twin_gated_counter_tb_top.sv
module twin_gated_counter_tb_top;
  localparam int N = 2;
  localparam int W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] rise_i = '0, fall_i = '0, clr_i = '0;
  logic [N-1:0][W-1:0] cnt_o;
  logic [N-1:0] tc_o;

  int n_chk = 0, n_bad = 0;
  int exp_cnt [N];
  bit a_lvl [N];
  bit b_lvl [N];

  always #2 clk_i = ~clk_i;

  twin_gated_counter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise_i), .fall_i(fall_i),
    .clr_i(clr_i), .cnt_o(cnt_o), .tc_o(tc_o));

  task automatic check_all(input string tag);
    for (int k = 0; k < N; k++) begin
      n_chk++;
      if (int'(cnt_o[k]) != exp_cnt[k] || tc_o[k] != (exp_cnt[k] == 15)) begin
        n_bad++;
        $display("FAIL %s ctr%0d cnt=%0d tc=%0b exp cnt=%0d tc=%0b", tag, k,
                 cnt_o[k], tc_o[k], exp_cnt[k], exp_cnt[k] == 15);
      end
    end
  endtask

  task automatic apply(input int g, input bit a, input bit b);
    bit qa, qb;
    string tag;
    qa = a && !a_lvl[g] && b_lvl[g];
    qb = !b && b_lvl[g] && !a_lvl[g];
    if (qa && qb)  tag = "R5";
    else if (qa)   tag = "R2";
    else if (qb)   tag = "R3";
    else           tag = "R4";
    if (qa || qb) exp_cnt[g] = (exp_cnt[g] + 1) % 16;
    a_lvl[g] = a; b_lvl[g] = b;
    rise_i[g] = a; fall_i[g] = b;
    repeat (6) @(negedge clk_i);
    check_all({tag, "/R1/R9"});
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin exp_cnt[k] = 0; a_lvl[k] = 0; b_lvl[k] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    check_all("R8 reset");

    // every ordered pair of input states, both bits switched together
    for (int rep = 0; rep < 2; rep++)
      for (int g = 0; g < N; g++)
        for (int f = 0; f < 4; f++)
          for (int t = 0; t < 4; t++) begin
            apply(g, f[1], f[0]);
            apply(g, t[1], t[0]);
          end

    // R6: count through wrap via rise input with enable held high
    apply(0, 0, 1);
    for (int i = 0; i < 18; i++) begin
      apply(0, 1, 1);
      apply(0, 0, 1);
    end
    // R6: same via fall input with other held low
    apply(1, 0, 0);
    for (int i = 0; i < 17; i++) begin
      apply(1, 0, 1);
      apply(1, 0, 0);
    end

    // R7: asynchronous clear while edges arrive
    apply(0, 0, 1);
    @(negedge clk_i);
    clr_i[0] = 1'b1;
    exp_cnt[0] = 0;
    #1;
    check_all("R7 async clear");
    for (int i = 0; i < 3; i++) begin
      rise_i[0] = 1'b1; repeat (4) @(negedge clk_i);
      rise_i[0] = 1'b0; repeat (4) @(negedge clk_i);
      check_all("R7 clear held");
    end
    rise_i[0] = 1'b1; a_lvl[0] = 1; repeat (4) @(negedge clk_i);
    clr_i[0] = 1'b0;
    repeat (8) @(negedge clk_i);
    check_all("R7 release steady");
    apply(0, 0, 1);
    apply(0, 1, 1);
    check_all("R7 counts after release");

    // R8: global reset mid-run with steady enable levels
    apply(1, 0, 1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int k = 0; k < N; k++) exp_cnt[k] = 0;
    #1;
    check_all("R8 async reset");
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    check_all("R8 release steady");
    apply(0, 0, 1);
    apply(1, 0, 0);
    check_all("R8 counts after release");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule